// File: doc/BRIEF.md
# Noise-Blanked Overcurrent Trip Qualifier

This block decides whether a high-level overcurrent comparator output is a real fault or switching noise. It takes two comparator levels that are already synchronised to the system clock. A rising edge on the first-level (lower threshold) comparator opens a blanking window. The window lasts a programmable number of clock cycles, chosen slightly longer than the expected noise burst (on the order of 100 ns). While the window is open, the second-level comparator cannot trip the output directly. Its activity is still remembered.

When the window closes, the block evaluates the second-level input. If that input is still high, or was seen high at any point during the window, the block drives a latched shutdown output. A pair of reason flags tells whether the trip came from the live level at expiry or from an earlier recorded event. If neither is true, the block returns to idle and the system keeps running.

Shutdown is released only through an explicit clear input, and only while the second-level input is low. All pins are plain control and status levels. There is no streamed data and therefore no valid/ready handshake.

Top module: `oc_trip_qualifier`

## Requirements
- R1: After reset, `shutdown_o`, `window_o`, `trip_live_o` and `trip_latched_o` are all low.
- R2: A rising edge of `lvl1_i` (high in a cycle after a low cycle), seen while no window is open and shutdown is low, raises `window_o` from the next cycle on. `window_o` stays high for exactly max(`delay_i`,1) cycles.
- R3: Rising edges of `lvl1_i` while a window is open or shutdown is high are ignored. An open window is never restarted or lengthened.
- R4: `lvl2_i` high while no window is open never raises `shutdown_o`.
- R5: If `lvl2_i` is high in the last window cycle, `shutdown_o` and `trip_live_o` rise in the following cycle, and `trip_latched_o` stays low.
- R6: If `lvl2_i` was high in any cycle from the first-level event cycle up to, but not including, the last window cycle, and is low in the last window cycle, `shutdown_o` and `trip_latched_o` rise in the following cycle, and `trip_live_o` stays low.
- R7: If `lvl2_i` stays low from the event cycle through the last window cycle, `shutdown_o` stays low and the block returns to idle.
- R8: Once `shutdown_o` is high, it stays high until a cycle with `clear_i` high and `lvl2_i` low. In the cycle after that, `shutdown_o` and both reason flags are low.
- R9: `clear_i` in a cycle where `lvl2_i` is high has no effect. `shutdown_o` and the reason flag stay as they were.
- R10: `delay_i` is captured only in the event cycle; changing it while the window is open does not change the window length. A value of 0 gives a one-cycle window.
- R11: While `shutdown_o` is high, exactly one reason flag is high. While it is low, both flags are low. `window_o` and `shutdown_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| lvl1_i | input | 1 | First-level comparator, synchronised |
| lvl2_i | input | 1 | Second-level comparator, synchronised |
| delay_i | input | DLY_W | Blanking length in clock cycles |
| clear_i | input | 1 | Request to release a latched shutdown |
| shutdown_o | output | 1 | Latched shutdown command |
| window_o | output | 1 | Blanking window open |
| trip_live_o | output | 1 | Trip caused by second level high at expiry |
| trip_latched_o | output | 1 | Trip caused by a recorded second-level event |

## Verification
Directed sequences each isolate one outcome of the window: second level quiet throughout, a short pulse that ends before expiry, and a level still high at expiry. Together these separate the no-trip, latched-reason and live-reason results. A re-rising first-level input mid-window, a delay changed mid-window, and a zero delay show whether the window length depends only on the delay captured at the event. Second-level activity outside any window, and clear attempts with the second level high and then low, show that the latch releases only under the right condition. A long seeded random run then mixes all of these against a cycle model built from the requirements.

// File: rtl/oc_trip_pkg.sv
package oc_trip_pkg;
  typedef enum logic [1:0] {
    REASON_NONE    = 2'd0,
    REASON_LIVE    = 2'd1,
    REASON_LATCHED = 2'd2
  } trip_reason_e;
endpackage

// File: rtl/oc_edge_det.sv
module oc_edge_det #(
  parameter bit RISING = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic edge_o
);
  logic prev_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sig_i;
  end

  generate
    if (RISING) begin : g_rise
      assign edge_o = sig_i & ~prev_q;
    end else begin : g_fall
      assign edge_o = ~sig_i & prev_q;
    end
  endgenerate
endmodule

// File: rtl/oc_blank_timer.sv
module oc_blank_timer #(
  parameter int DLY_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DLY_W-1:0] load_i,
  output logic             active_o,
  output logic             expire_o
);
  localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

  logic [DLY_W-1:0] cnt_q;
  logic             active_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (start_i && !active_q) begin
      cnt_q    <= (load_i == '0) ? ONE : load_i;
      active_q <= 1'b1;
    end else if (active_q) begin
      if (cnt_q == ONE) active_q <= 1'b0;
      else              cnt_q    <= cnt_q - ONE;
    end
  end

  assign active_o = active_q;
  assign expire_o = active_q && (cnt_q == ONE);
endmodule

// File: rtl/oc_trip_latch.sv
module oc_trip_latch
  import oc_trip_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic live_i,
  input  logic seen_i,
  input  logic clear_i,
  output logic shutdown_o,
  output logic live_flag_o,
  output logic latched_flag_o
);
  trip_reason_e reason_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      reason_q <= REASON_NONE;
    end else if (reason_q == REASON_NONE) begin
      if (expire_i && live_i)      reason_q <= REASON_LIVE;
      else if (expire_i && seen_i) reason_q <= REASON_LATCHED;
    end else if (clear_i && !live_i) begin
      reason_q <= REASON_NONE;
    end
  end

  assign shutdown_o     = (reason_q != REASON_NONE);
  assign live_flag_o    = (reason_q == REASON_LIVE);
  assign latched_flag_o = (reason_q == REASON_LATCHED);
endmodule

// File: rtl/oc_trip_qualifier.sv
module oc_trip_qualifier #(
  parameter int DLY_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lvl1_i,
  input  logic             lvl2_i,
  input  logic [DLY_W-1:0] delay_i,
  input  logic             clear_i,
  output logic             shutdown_o,
  output logic             window_o,
  output logic             trip_live_o,
  output logic             trip_latched_o
);
  logic lvl1_rise;
  logic win_active;
  logic win_expire;
  logic start;
  logic seen_q;
  logic sd;

  oc_edge_det #(.RISING(1'b1)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (lvl1_i),
    .edge_o (lvl1_rise)
  );

  assign start = lvl1_rise && !win_active && !sd;

  oc_blank_timer #(.DLY_W(DLY_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .load_i   (delay_i),
    .active_o (win_active),
    .expire_o (win_expire)
  );

  // Remember masked second-level activity from the event cycle onward.
  always_ff @(posedge clk_i) begin
    if (!rst_ni)         seen_q <= 1'b0;
    else if (start)      seen_q <= lvl2_i;
    else if (win_active) seen_q <= seen_q | lvl2_i;
  end

  oc_trip_latch u_latch (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .expire_i       (win_expire),
    .live_i         (lvl2_i),
    .seen_i         (seen_q),
    .clear_i        (clear_i),
    .shutdown_o     (sd),
    .live_flag_o    (trip_live_o),
    .latched_flag_o (trip_latched_o)
  );

  assign shutdown_o = sd;
  assign window_o   = win_active;
endmodule

// File: rtl/oc_trip_qualifier_chk.sv
module oc_trip_qualifier_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic lvl1_i,
  input logic lvl2_i,
  input logic clear_i,
  input logic shutdown_o,
  input logic window_o,
  input logic trip_live_o,
  input logic trip_latched_o
);
  assert_window_needs_edge_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(window_o) |-> $past(lvl1_i));

  assert_idle_no_trip_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !window_o |=> !$rose(shutdown_o));

  assert_live_reason_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(shutdown_o) && trip_live_o) |-> $past(lvl2_i));

  assert_latched_reason_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(shutdown_o) && trip_latched_o) |-> !$past(lvl2_i));

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shutdown_o && !(clear_i && !lvl2_i)) |=> shutdown_o);

  assert_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shutdown_o && clear_i && !lvl2_i) |=> !shutdown_o);

  assert_clear_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shutdown_o && clear_i && lvl2_i) |=> (shutdown_o && $stable(trip_live_o)));

  assert_flags_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_o |-> $onehot({trip_live_o, trip_latched_o}));

  assert_flags_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shutdown_o |-> !(trip_live_o || trip_latched_o));

  assert_exclusive_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(window_o && shutdown_o));
endmodule

bind oc_trip_qualifier oc_trip_qualifier_chk chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .lvl1_i         (lvl1_i),
  .lvl2_i         (lvl2_i),
  .clear_i        (clear_i),
  .shutdown_o     (shutdown_o),
  .window_o       (window_o),
  .trip_live_o    (trip_live_o),
  .trip_latched_o (trip_latched_o)
);

// File: tb/oc_trip_qualifier_tb_top.sv
`timescale 1ns/1ps
module oc_trip_qualifier_tb_top;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l1 = 1'b0, l2 = 1'b0, clr = 1'b0;
  logic [DW-1:0] dly = '0;
  logic sd, win, live, lat;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // reference model state
  bit m_prev1, m_win, m_seen, m_sd, m_live, m_lat;
  int m_cnt;

  always #5 clk = ~clk;

  oc_trip_qualifier #(.DLY_W(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .lvl1_i(l1), .lvl2_i(l2), .delay_i(dly),
    .clear_i(clr), .shutdown_o(sd), .window_o(win), .trip_live_o(live),
    .trip_latched_o(lat)
  );

  function automatic int win_len(input int d);
    return (d == 0) ? 1 : d;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_prev1 = 0; m_win = 0; m_seen = 0; m_sd = 0; m_live = 0; m_lat = 0; m_cnt = 0;
  endtask

  task automatic model_step(input bit a1, input bit a2, input int ad, input bit ac);
    bit rise, start, expire;
    rise = a1 && !m_prev1;
    m_prev1 = a1;
    start = rise && !m_win && !m_sd;
    expire = m_win && (m_cnt == 1);
    if (!m_sd && expire && (a2 || m_seen)) begin
      m_sd = 1; m_live = a2; m_lat = !a2;
    end else if (m_sd && ac && !a2) begin
      m_sd = 0; m_live = 0; m_lat = 0;
    end
    if (start) m_seen = a2;
    else if (m_win) m_seen = m_seen | a2;
    if (start) begin
      m_cnt = win_len(ad); m_win = 1;
    end else if (m_win) begin
      if (m_cnt == 1) m_win = 0;
      else m_cnt--;
    end
  endtask

  task automatic step(input bit a1, input bit a2, input int ad, input bit ac);
    @(negedge clk);
    l1 = a1; l2 = a2; dly = DW'(ad); clr = ac;
    @(posedge clk);
    model_step(a1, a2, ad, ac);
    #1;
    check("R2 window", int'(win), int'(m_win));
    check("R5 shutdown", int'(sd), int'(m_sd));
    check("R5 live flag", int'(live), int'(m_live));
    check("R6 latched flag", int'(lat), int'(m_lat));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int n;
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    check("R1 shutdown", int'(sd), 0);
    check("R1 window", int'(win), 0);
    check("R1 flags", int'({live, lat}), 0);
    @(negedge clk); rst_n = 1'b1;

    // R2/R7: quiet second level, window length 5, no trip
    step(1, 0, 5, 0); n = int'(win);
    repeat (12) begin step(0, 0, 5, 0); n += int'(win); end
    check("R2 window length", n, 5);
    check("R7 no trip", int'(sd), 0);

    // R10: delay changed mid-window
    step(1, 0, 7, 0); n = int'(win);
    repeat (14) begin step(0, 0, 2, 0); n += int'(win); end
    check("R10 captured delay", n, 7);

    // R10: zero delay gives one cycle
    step(1, 0, 0, 0); n = int'(win);
    repeat (5) begin step(0, 0, 0, 0); n += int'(win); end
    check("R10 zero delay", n, 1);

    // R3: re-rise of first level mid-window
    step(1, 0, 8, 0); n = int'(win);
    step(0, 0, 8, 0); n += int'(win);
    step(1, 0, 8, 0); n += int'(win);
    repeat (12) begin step(0, 0, 8, 0); n += int'(win); end
    check("R3 no restart", n, 8);

    // R4: second level high with no window open
    repeat (6) step(0, 1, 4, 0);
    check("R4 idle no trip", int'(sd), 0);
    step(0, 0, 4, 0);

    // R6: pulse during window, low at expiry
    step(1, 0, 6, 0);
    step(0, 1, 6, 0);
    repeat (8) step(0, 0, 6, 0);
    check("R6 latched trip", int'({sd, live, lat}), 3'b101);
    step(1, 0, 6, 0);
    check("R3 ignored in shutdown", int'(win), 0);
    step(0, 0, 6, 1);
    check("R8 release", int'({sd, live, lat}), 0);

    // R5/R9: live at expiry, clear while high ignored
    step(1, 0, 4, 0);
    repeat (6) step(0, 1, 4, 0);
    check("R5 live trip", int'({sd, live, lat}), 3'b110);
    step(0, 1, 4, 1);
    check("R9 clear ignored", int'({sd, live, lat}), 3'b110);
    step(0, 0, 4, 0);
    check("R8 holds without clear", int'(sd), 1);
    step(0, 0, 4, 1);
    check("R8 release after drop", int'(sd), 0);

    // R11 and all others: seeded random run against the model
    for (int i = 0; i < 4000; i++) begin
      bit a1, a2, ac;
      int ad;
      a1 = ($urandom % 6) == 0;
      a2 = ($urandom % 5) == 0;
      ac = ($urandom % 8) == 0;
      ad = $urandom % 10;
      step(a1, a2, ad, ac);
      if (sd) check("R11 one flag", int'(live) + int'(lat), 1);
      check("R11 exclusive", int'(win && sd), 0);
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule